// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time-clock peripheral on a simple 32-bit register bus. It keeps a free-running binary seconds count that advances on a once-per-second tick input. It also holds an alarm compare value, two sticky event flags (tick event and alarm match) and their interrupt enables. The enables and flags combine into a single interrupt line. A scratchpad word keeps its contents, so software can store a signature there and later check whether state was lost. A one-bit hibernate register drives a power-off request level.

Reads are combinational from the offset. Writes go through a write-ready handshake that models a slow clock domain behind the bus. An accepted write takes the ready bit low for a fixed number of cycles and commits at the end of that window. A write that arrives while ready is low is dropped. The event flags clear when software writes 0 to them and stay set when it writes 1. A read-modify-write of the control word therefore keeps pending events as long as it writes 1s into the flag positions.

Top module: `secrtc_top`

## Requirements
- R1: After reset, control reads 0x80 (only write-ready set), and seconds, alarm, scratchpad and hibernate read 0. The interrupt and hibernate request outputs are low.
- R2: A write accepted while write-ready (control bit 7) is 1 drives write-ready low for exactly WR_LAT cycles (default 4). The old register value stays visible throughout that window, and the new value is readable once write-ready returns to 1.
- R3: A bus write issued while write-ready is 0 has no effect on any register.
- R4: With counter enable (control bit 0) set, each tick pulse raises the seconds count by one. With it clear, ticks leave the count unchanged.
- R5: A tick taken while counter enable is set sets the tick event flag (control bit 6).
- R6: When alarm enable (control bit 2) is set and the incremented seconds value equals the alarm register (offset 0x08), the alarm flag (control bit 4) is set on that tick. With alarm enable clear, the match sets nothing.
- R7: Writing 0 to control bit 6 or bit 4 clears that flag, and writing 1 leaves it unchanged. The enable bits 5, 3, 2 and 0 take the written value.
- R8: The interrupt output is high exactly when (tick flag and tick interrupt enable, bit 5) or (alarm flag and alarm interrupt enable, bit 3).
- R9: The scratchpad at 0x34 is a full 32-bit read/write word. Bit 0 of the hibernate register at 0x20 is readable and drives the hibernate request output.
- R10: Reads of unmapped offsets, including the reserved 0x0C, return zero, and writes to them change nothing readable.
- R11: Seconds (offset 0x04) is a 32-bit value that software loads by writing. It wraps from 0xFFFFFFFF to 0 on a tick.
- R12: If a committed write to seconds and a counting tick fall in the same cycle, the written value is kept. The tick still sets the tick flag, even when the same commit writes 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, accepted only while write-ready is 1 |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_1hz | input | 1 | One-cycle pulse per second |
| irq | output | 1 | Combined interrupt request |
| hib_req | output | 1 | Hibernate (power-off) request level |

## Verification
The assertions assume that tick_1hz is a single-cycle strobe. They also assume that software writes only while write-ready reads 1. A write sent during the busy window is allowed, but it must be dropped. The directed tasks raise the tick for exactly one clock. They poll write-ready before every legal write and hold bus_wr for one cycle. The single deliberate exception is the R3 task, which issues one write inside the busy window on purpose.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_CTRL    = 6'h00;
    localparam logic [OFS_W-1:0] OFS_SECS    = 6'h04;
    localparam logic [OFS_W-1:0] OFS_ALARM   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_HIB     = 6'h20;
    localparam logic [OFS_W-1:0] OFS_SCRATCH = 6'h34;

    localparam int BIT_READY = 7;
    localparam int BIT_TFLAG = 6;
    localparam int BIT_TIE   = 5;
    localparam int BIT_AFLAG = 4;
    localparam int BIT_AIE   = 3;
    localparam int BIT_AEN   = 2;
    localparam int BIT_CEN   = 0;

    typedef struct packed {
        logic tick_flag;
        logic tick_ie;
        logic alm_flag;
        logic alm_ie;
        logic alm_en;
        logic cnt_en;
    } ctrl_t;
endpackage

// File: rtl/secrtc_wrgate.sv
module secrtc_wrgate #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int WR_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              commit,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data
);
    localparam int CNT_W = $clog2(WR_LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) begin
            if (wr_req) begin
                st_d.cnt  = CNT_W'(WR_LAT);
                st_d.addr = wr_addr;
                st_d.data = wr_data;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready   = (st_q.cnt == '0);
    assign commit  = (st_q.cnt == CNT_W'(1));
    assign cm_addr = st_q.addr;
    assign cm_data = st_q.data;
endmodule

// File: rtl/secrtc_core.sv
module secrtc_core
    import secrtc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [DATA_W-1:0] cm_data,
    output logic [DATA_W-1:0] secs,
    output logic [DATA_W-1:0] alarm,
    output logic [DATA_W-1:0] scratch,
    output ctrl_t             ctrl,
    output logic              hib
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] secs;
        logic [DATA_W-1:0] alarm;
        logic [DATA_W-1:0] scratch;
        logic              hib;
    } core_t;

    core_t             st_d, st_q;
    logic [DATA_W-1:0] secs_inc;
    logic              secs_wr;

    always_comb begin
        st_d     = st_q;
        secs_inc = st_q.secs + 1'b1;
        secs_wr  = commit && (cm_addr == ADDR_W'(OFS_SECS));
        if (commit) begin
            unique case (cm_addr)
                ADDR_W'(OFS_CTRL): begin
                    st_d.ctrl.cnt_en    = cm_data[BIT_CEN];
                    st_d.ctrl.alm_en    = cm_data[BIT_AEN];
                    st_d.ctrl.alm_ie    = cm_data[BIT_AIE];
                    st_d.ctrl.tick_ie   = cm_data[BIT_TIE];
                    st_d.ctrl.alm_flag  = st_q.ctrl.alm_flag  & cm_data[BIT_AFLAG];
                    st_d.ctrl.tick_flag = st_q.ctrl.tick_flag & cm_data[BIT_TFLAG];
                end
                ADDR_W'(OFS_SECS):    st_d.secs    = cm_data;
                ADDR_W'(OFS_ALARM):   st_d.alarm   = cm_data;
                ADDR_W'(OFS_SCRATCH): st_d.scratch = cm_data;
                ADDR_W'(OFS_HIB):     st_d.hib     = cm_data[0];
                default: ;
            endcase
        end
        if (tick && st_q.ctrl.cnt_en) begin
            if (!secs_wr) st_d.secs = secs_inc;
            st_d.ctrl.tick_flag = 1'b1;
            if (st_q.ctrl.alm_en && (secs_inc == st_q.alarm))
                st_d.ctrl.alm_flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign secs    = st_q.secs;
    assign alarm   = st_q.alarm;
    assign scratch = st_q.scratch;
    assign ctrl    = st_q.ctrl;
    assign hib     = st_q.hib;
endmodule

// File: rtl/secrtc_top.sv
module secrtc_top
    import secrtc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int WR_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_1hz,
    output logic              irq,
    output logic              hib_req
);
    logic              wr_ready;
    logic              commit;
    logic [ADDR_W-1:0] cm_addr;
    logic [DATA_W-1:0] cm_data;
    logic [DATA_W-1:0] secs, alarm, scratch;
    ctrl_t             ctrl;
    logic              hib;
    logic [7:0]        ctrl_byte;

    secrtc_wrgate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LAT(WR_LAT)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .ready   (wr_ready),
        .commit  (commit),
        .cm_addr (cm_addr),
        .cm_data (cm_data)
    );

    secrtc_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .commit  (commit),
        .cm_addr (cm_addr),
        .cm_data (cm_data),
        .secs    (secs),
        .alarm   (alarm),
        .scratch (scratch),
        .ctrl    (ctrl),
        .hib     (hib)
    );

    always_comb begin
        ctrl_byte            = '0;
        ctrl_byte[BIT_READY] = wr_ready;
        ctrl_byte[BIT_TFLAG] = ctrl.tick_flag;
        ctrl_byte[BIT_TIE]   = ctrl.tick_ie;
        ctrl_byte[BIT_AFLAG] = ctrl.alm_flag;
        ctrl_byte[BIT_AIE]   = ctrl.alm_ie;
        ctrl_byte[BIT_AEN]   = ctrl.alm_en;
        ctrl_byte[BIT_CEN]   = ctrl.cnt_en;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL):    bus_rdata = DATA_W'(ctrl_byte);
            ADDR_W'(OFS_SECS):    bus_rdata = secs;
            ADDR_W'(OFS_ALARM):   bus_rdata = alarm;
            ADDR_W'(OFS_SCRATCH): bus_rdata = scratch;
            ADDR_W'(OFS_HIB):     bus_rdata = DATA_W'(hib);
            default:              bus_rdata = '0;
        endcase
    end

    assign irq     = (ctrl.tick_flag & ctrl.tick_ie) | (ctrl.alm_flag & ctrl.alm_ie);
    assign hib_req = hib;
endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              wr_ready,
    input logic              tick,
    input logic              commit,
    input logic              cnt_en,
    input logic [DATA_W-1:0] secs,
    input logic              tick_flag,
    input logic              alm_flag,
    input logic              irq,
    input logic              hib_req
);
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_ready) |=> !wr_ready);

    assert_hib_only_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(hib_req));

    assert_secs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !tick) |=> $stable(secs));

    assert_tick_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && !commit) |=> (secs == $past(secs) + DATA_W'(1)));

    assert_tick_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en) |=> tick_flag);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_flag && !alm_flag) |-> !irq);
endmodule

bind secrtc_top secrtc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .wr_ready  (wr_ready),
    .tick      (tick_1hz),
    .commit    (commit),
    .cnt_en    (ctrl.cnt_en),
    .secs      (secs),
    .tick_flag (ctrl.tick_flag),
    .alm_flag  (ctrl.alm_flag),
    .irq       (irq),
    .hib_req   (hib_req)
);

// File: tb/sim_secrtc_top.sv
module sim_secrtc_top;
    localparam int WR_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1hz = 1'b0;
    logic        irq;
    logic        hib_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    secrtc_top #(.WR_LAT(WR_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1hz(tick_1hz),
        .irq(irq), .hib_req(hib_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        peek(a, d);
        chk(req, d, exp);
    endtask

    task automatic wait_ready();
        logic [31:0] d;
        peek(6'h00, d);
        while (d[7] !== 1'b1) begin
            @(negedge clk);
            peek(6'h00, d);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        wait_ready();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_ready();
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 6'h00, 32'h80);
        expect_reg("R1 secs", 6'h04, 32'h0);
        expect_reg("R1 alarm", 6'h08, 32'h0);
        expect_reg("R1 scratch", 6'h34, 32'h0);
        expect_reg("R1 hib", 6'h20, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 hib_req", 32'(hib_req), 32'h0);
    endtask

    task automatic t_count_disabled();
        pulse_tick();
        expect_reg("R4 disabled count", 6'h04, 32'h0);
    endtask

    task automatic t_ready_window();
        int n;
        logic [31:0] d;
        @(negedge clk);
        wait_ready();
        bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h55;
        @(negedge clk);
        bus_wr = 1'b0;
        n = 0;
        peek(6'h00, d);
        while (d[7] == 1'b0 && n < 20) begin
            n++;
            if (n == WR_LAT) expect_reg("R2 old value in window", 6'h04, 32'h0);
            @(negedge clk);
            peek(6'h00, d);
        end
        chk("R2 busy cycles", 32'(n), 32'(WR_LAT));
        expect_reg("R2 committed value", 6'h04, 32'h55);
    endtask

    task automatic t_busy_ignored();
        @(negedge clk);
        wait_ready();
        bus_wr = 1'b1; bus_addr = 6'h34; bus_wdata = 32'hA5A5_0001;
        @(negedge clk);
        bus_addr = 6'h34; bus_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_ready();
        repeat (WR_LAT + 2) @(negedge clk);
        expect_reg("R3 busy write dropped", 6'h34, 32'hA5A5_0001);
    endtask

    task automatic t_count_and_flag();
        bus_write(6'h00, 32'h01);
        pulse_tick();
        expect_reg("R4 count", 6'h04, 32'h56);
        expect_reg("R5 tick flag", 6'h00, 32'hC1);
    endtask

    task automatic t_alarm();
        bus_write(6'h08, 32'h57);
        pulse_tick();
        expect_reg("R6 no alarm when disabled", 6'h00, 32'hC1);
        bus_write(6'h00, 32'h05);
        bus_write(6'h08, 32'h58);
        pulse_tick();
        expect_reg("R6 secs at match", 6'h04, 32'h58);
        expect_reg("R6 alarm flag", 6'h00, 32'hD5);
        chk("R8 no irq without enables", 32'(irq), 32'h0);
    endtask

    task automatic t_flag_clear();
        bus_write(6'h00, 32'h45);
        expect_reg("R7 keep tick clear alarm", 6'h00, 32'hC5);
        bus_write(6'h00, 32'h05);
        expect_reg("R7 clear tick", 6'h00, 32'h85);
    endtask

    task automatic t_irq();
        pulse_tick();
        expect_reg("R8 tick flag only", 6'h00, 32'hC5);
        chk("R8 irq off without tick enable", 32'(irq), 32'h0);
        bus_write(6'h00, 32'h65);
        chk("R8 tick irq", 32'(irq), 32'h1);
        bus_write(6'h00, 32'h25);
        expect_reg("R8 ctrl after clear", 6'h00, 32'hA5);
        chk("R8 irq drops", 32'(irq), 32'h0);
        bus_write(6'h08, 32'h5A);
        bus_write(6'h00, 32'h0D);
        pulse_tick();
        expect_reg("R8 both flags", 6'h00, 32'hDD);
        chk("R8 alarm irq", 32'(irq), 32'h1);
        bus_write(6'h00, 32'h0D);
        chk("R8 alarm irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic t_wrap();
        bus_write(6'h00, 32'h01);
        bus_write(6'h04, 32'hFFFF_FFFF);
        expect_reg("R11 load", 6'h04, 32'hFFFF_FFFF);
        pulse_tick();
        expect_reg("R11 wrap", 6'h04, 32'h0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        wait_ready();
        bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h100;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (WR_LAT - 1) @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        wait_ready();
        expect_reg("R12 write wins", 6'h04, 32'h100);
        @(negedge clk);
        wait_ready();
        bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h01;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (WR_LAT - 1) @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        wait_ready();
        expect_reg("R12 tick beats clear", 6'h00, 32'hC1);
    endtask

    task automatic t_scratch_hib();
        bus_write(6'h34, 32'h1234_5678);
        expect_reg("R9 scratch", 6'h34, 32'h1234_5678);
        bus_write(6'h20, 32'h1);
        expect_reg("R9 hib reg", 6'h20, 32'h1);
        chk("R9 hib_req high", 32'(hib_req), 32'h1);
        bus_write(6'h20, 32'h0);
        chk("R9 hib_req low", 32'(hib_req), 32'h0);
    endtask

    task automatic t_unmapped();
        bus_write(6'h0C, 32'hFFFF_FFFF);
        expect_reg("R10 reserved 0x0C", 6'h0C, 32'h0);
        expect_reg("R10 offset 0x10", 6'h10, 32'h0);
        expect_reg("R10 offset 0x3C", 6'h3C, 32'h0);
        expect_reg("R10 scratch untouched", 6'h34, 32'h1234_5678);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_disabled();
        t_ready_window();
        t_busy_ignored();
        t_count_and_flag();
        t_alarm();
        t_flag_clear();
        t_irq();
        t_wrap();
        t_collide();
        t_scratch_hib();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule